// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a serial-bus slave that lets a bus master write and read a 256-entry, byte-wide register file. It runs on a system clock that oversamples the bus by at least eight times. The clock and data lines are synchronized into that domain. Start and stop conditions, clock edges and data bits are all recovered from the synchronized copies. The data line is open-drain: the block only pulls it low, through an output-enable. One strap input chooses which of two 7-bit device addresses the slave answers to.

A write transfer carries a register address byte after the device address. That byte loads an internal pointer. Each data byte that follows is stored at the pointer, and the pointer then steps forward by one, wrapping at the top of the file. A repeated start with the read direction shifts out register contents from the current pointer, one byte per acknowledge from the master. The surrounding logic reads the register file combinationally through a separate address/data port.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset every register holds 0x00 and the data-line output-enable is low.
- R2: The slave answers device address 0x1A (address byte 0x34 for write) when the strap is 0, and 0x1B (byte 0x36) when the strap is 1, by pulling the data line low during the ninth clock of that byte.
- R3: If the address does not match, the slave leaves the data line released and ignores every following byte until the next start condition.
- R4: In a write transfer, the byte after the device address is acknowledged and becomes the register pointer.
- R5: Each data byte in a write is acknowledged and stored at the pointer, after which the pointer increments by one; a burst keeps going until a stop.
- R6: The pointer wraps from 0xFF to 0x00 during a burst.
- R7: After a repeated start with the direction bit set to 1, the slave sends the register at the pointer, MSB first, incrementing the pointer after each byte, for as long as the master acknowledges.
- R8: When the master does not acknowledge a read byte, the slave stops driving the data line and sends nothing more until the next start.
- R9: A stop condition at any point returns the slave to idle; a partly received data byte is not written.
- R10: The register read port returns the contents of the register selected by its address input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| addrStrap | input | 1 | Selects the device address: 0 gives 0x1A, 1 gives 0x1B |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | When high, the pad pulls the data line low |
| regAddr | input | 8 | Register read port address |
| regData | output | 8 | Contents of the register at regAddr |

## Verification
The assertions watch, on every cycle, that the output-enable rises only while the synchronized bus clock is low, that idle and ignoring states never drive the bus, that a start always leads to address reception and a stop to idle, and that every register write steps the pointer by one with the wrap at 0xFF. Only the bench's transfers can show the byte-level outcomes: which address values are acknowledged under each strap setting, the data actually stored, the byte order of read bursts, the release after a master's negative acknowledge, and that a transfer broken by a stop leaves the register file untouched.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int PTR_W  = 8;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } slvState_e;

  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic setPtr;
    logic wrReg;
    logic loadTx;
    logic shiftTx;
    logic sampleAck;
  } ctrlStrobes_t;

endpackage

// File: rtl/i2c_reg_dp.sv
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  ctrlStrobes_t        strb,
  input  logic [PTR_W-1:0]    regAddr,
  output logic [BYTE_W-1:0]   regData,
  output logic                sclS,
  output logic                sclRise,
  output logic                sclFall,
  output logic                startDet,
  output logic                stopDet,
  output logic [BYTE_W-1:0]   rxByte,
  output logic                byteDone,
  output logic                txLast,
  output logic                txBit,
  output logic                masterNack,
  output logic [PTR_W-1:0]    ptr
);

  localparam int DEPTH = 1 << PTR_W;

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sdaS, sclPrev, sdaPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] mem [DEPTH];

  // input synchronizers, depth set by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclChain[SYNC_STAGES-1];
  assign sdaS = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // bit counter and shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      rxByte     <= '0;
      txShift    <= '0;
      masterNack <= 1'b1;
    end else begin
      if (strb.clrCnt)
        bitCnt <= '0;
      else if (strb.shiftIn || strb.shiftTx)
        bitCnt <= bitCnt + 1'b1;
      if (strb.shiftIn)
        rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (strb.loadTx)
        txShift <= mem[ptr];
      else if (strb.shiftTx)
        txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (strb.sampleAck)
        masterNack <= sdaS;
    end
  end

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign txLast   = (bitCnt == CNT_W'(BYTE_W - 1));
  assign txBit    = txShift[BYTE_W-1];

  // register pointer and register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.setPtr)
        ptr <= rxByte[PTR_W-1:0];
      else if (strb.wrReg || strb.loadTx)
        ptr <= ptr + 1'b1;
      if (strb.wrReg)
        mem[ptr] <= rxByte;
    end
  end

  assign regData = mem[regAddr];

endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_BASE = 7'h1A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrap,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              byteDone,
  input  logic              txLast,
  input  logic              masterNack,
  output ctrlStrobes_t      strb,
  output logic              driveAck,
  output logic              txActive,
  output slvState_e         state
);

  slvState_e nextState;
  logic      isRead, isReadNext;
  logic [6:0] devAddr;

  assign devAddr = DEV_ADDR_BASE | {6'b0, addrStrap};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
    end else begin
      state  <= nextState;
      isRead <= isReadNext;
    end
  end

  always_comb begin
    nextState  = state;
    isReadNext = isRead;
    strb       = '0;
    if (startDet) begin
      nextState   = ST_ADDR;
      strb.clrCnt = 1'b1;
    end else if (stopDet) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (sclRise && !byteDone) strb.shiftIn = 1'b1;
          if (sclFall && byteDone) begin
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == devAddr) begin
                nextState  = ST_ADDR_ACK;
                isReadNext = rxByte[0];
              end else begin
                nextState = ST_IGNORE;
              end
            end else if (state == ST_SUB) begin
              strb.setPtr = 1'b1;
              nextState   = ST_SUB_ACK;
            end else begin
              strb.wrReg = 1'b1;
              nextState  = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            strb.clrCnt = 1'b1;
            if (isRead) begin
              strb.loadTx = 1'b1;
              nextState   = ST_TX;
            end else begin
              nextState = ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            strb.clrCnt = 1'b1;
            nextState   = ST_WDATA;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (txLast) nextState = ST_MACK;
            else        strb.shiftTx = 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) strb.sampleAck = 1'b1;
          if (sclFall) begin
            if (!masterNack) begin
              strb.clrCnt = 1'b1;
              strb.loadTx = 1'b1;
              nextState   = ST_TX;
            end else begin
              nextState = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign driveAck = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) ||
                    (state == ST_WDATA_ACK);
  assign txActive = (state == ST_TX);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_BASE = 7'h1A,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrap,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [PTR_W-1:0]  regAddr,
  output logic [BYTE_W-1:0] regData
);

  ctrlStrobes_t      strb;
  slvState_e         state;
  logic              sclS, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic              byteDone, txLast, txBit, masterNack;
  logic              driveAck, txActive;
  logic [PTR_W-1:0]  ptr;

  i2c_reg_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .regAddr(regAddr), .regData(regData), .sclS(sclS), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .byteDone(byteDone), .txLast(txLast), .txBit(txBit),
    .masterNack(masterNack), .ptr(ptr)
  );

  i2c_reg_ctrl #(.DEV_ADDR_BASE(DEV_ADDR_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .addrStrap(addrStrap), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .byteDone(byteDone), .txLast(txLast),
    .masterNack(masterNack), .strb(strb), .driveAck(driveAck),
    .txActive(txActive), .state(state)
  );

  assign sdaOe = driveAck | (txActive & ~txBit);

endmodule

// File: rtl/i2c_reg_chk.sv
module i2c_reg_chk
  import i2c_reg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sdaOe,
  input logic             sclS,
  input logic             startDet,
  input logic             stopDet,
  input slvState_e        state,
  input logic             wrStb,
  input logic [PTR_W-1:0] ptr
);

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS); // R2

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R1

  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaOe); // R3

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR)); // R2

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE)); // R9

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && ptr != '1) |=> (ptr == $past(ptr) + 1'b1)); // R5

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && ptr == '1) |=> (ptr == '0)); // R6

endmodule

bind i2c_reg_slave i2c_reg_chk uChk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclS(sclS), .startDet(startDet),
  .stopDet(stopDet), .state(state), .wrStb(strb.wrReg), .ptr(ptr)
);

// File: tb/tb_i2c_reg_slave.sv
`timescale 1ns/1ps
module tb_i2c_reg_slave;

  localparam int Q = 5;  // quarter bus period in system clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrStrap = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaOe;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regData;
  logic       sdaBus;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  assign sdaBus = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  i2c_reg_slave dut (
    .clk(clk), .rstN(rstN), .addrStrap(addrStrap), .sclIn(sclM),
    .sdaIn(sdaBus), .sdaOe(sdaOe), .regAddr(regAddr), .regData(regData)
  );

  // strap, sub-address, data
  localparam logic [16:0] VECS [6] = '{
    {1'b0, 8'h00, 8'h5A},
    {1'b0, 8'h01, 8'hA5},
    {1'b0, 8'h7F, 8'hFF},
    {1'b1, 8'h80, 8'h01},
    {1'b1, 8'hC3, 8'h3C},
    {1'b0, 8'h10, 8'h96}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitq(1);
    sclM = 1'b1; waitq(2);
    sdaM = 1'b0; waitq(2);
    sclM = 1'b0; waitq(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitq(1);
    sclM = 1'b1; waitq(2);
    sdaM = 1'b1; waitq(2);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitq(1);
    sclM = 1'b1; waitq(2);
    sclM = 1'b0; waitq(1);
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; waitq(1);
    sclM = 1'b1; waitq(1);
    b = sdaBus; waitq(1);
    sclM = 1'b0; waitq(1);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    readBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) readBit(d[i]);
    sendBit(nack);
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    @(negedge clk);
    d = regData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [7:0] r0, r1, r2;
    repeat (4) @(negedge clk);
    // R1: reset contents and released bus
    chk("R1 oe", sdaOe, 0);
    peek(8'h00, d); chk("R1 reg00", d, 8'h00);
    peek(8'h55, d); chk("R1 reg55", d, 8'h00);
    peek(8'hFF, d); chk("R1 regFF", d, 8'h00);
    rstN = 1'b1;
    waitq(2);

    // vector table: byte writes under both strap settings (R2 R4 R5 R10)
    for (int v = 0; v < 6; v++) begin
      logic [16:0] e;
      logic a0, a1, a2;
      e = VECS[v];
      addrStrap = e[16];
      waitq(1);
      busStart();
      sendByte(e[16] ? 8'h36 : 8'h34, a0);
      sendByte(e[15:8], a1);
      sendByte(e[7:0], a2);
      busStop();
      chk("R2 addr ack", a0, 1);
      chk("R4 sub ack", a1, 1);
      chk("R5 data ack", a2, 1);
      peek(e[15:8], d); chk("R10 readback", d, e[7:0]);
    end

    // R3: strap 0, address 0x1B is foreign; following bytes ignored
    addrStrap = 1'b0;
    busStart();
    sendByte(8'h36, ack); chk("R3 no addr ack", ack, 0);
    sendByte(8'h10, ack); chk("R3 no sub ack", ack, 0);
    sendByte(8'h11, ack); chk("R3 no data ack", ack, 0);
    busStop();
    peek(8'h10, d); chk("R3 reg10 kept", d, 8'h96);

    // R5 R6: burst from 0xFE wraps to 0x00
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'hFE, ack);
    sendByte(8'hA1, ack);
    sendByte(8'hB2, ack);
    sendByte(8'hC3, ack); chk("R5 burst ack", ack, 1);
    busStop();
    peek(8'hFE, d); chk("R5 regFE", d, 8'hA1);
    peek(8'hFF, d); chk("R6 regFF", d, 8'hB2);
    peek(8'h00, d); chk("R6 reg00 wrapped", d, 8'hC3);

    // R7 R8: set pointer, repeated start, read burst, NACK
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'hFE, ack);
    busStart();
    sendByte(8'h35, ack); chk("R7 read addr ack", ack, 1);
    recvByte(1'b0, r0);
    recvByte(1'b0, r1);
    recvByte(1'b1, r2);
    chk("R7 byte0", r0, 8'hA1);
    chk("R7 byte1", r1, 8'hB2);
    chk("R7 byte2 wrap", r2, 8'hC3);
    for (int i = 7; i >= 0; i--) readBit(d[i]);
    chk("R8 released after nack", d, 8'hFF);
    chk("R8 oe low", sdaOe, 0);
    busStop();

    // R9: stop in the middle of a data byte
    busStart();
    sendByte(8'h34, ack);
    sendByte(8'h20, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStop();
    chk("R9 idle oe", sdaOe, 0);
    peek(8'h20, d); chk("R9 partial not written", d, 8'h00);
    busStart();
    sendByte(8'h34, ack); chk("R9 new transfer ack", ack, 1);
    sendByte(8'h20, ack);
    sendByte(8'h77, ack);
    busStop();
    peek(8'h20, d); chk("R9 write after stop", d, 8'h77);

    // R2: strap 1 read of one byte at 0x80
    addrStrap = 1'b1;
    busStart();
    sendByte(8'h36, ack);
    sendByte(8'h80, ack);
    busStart();
    sendByte(8'h37, ack); chk("R2 strap1 read ack", ack, 1);
    recvByte(1'b1, r0); chk("R7 strap1 data", r0, 8'h01);
    busStop();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule